// File: doc/BRIEF.md
# Receive/Transmit Byte Queue Pair with Fill Thresholds

This block buffers serial traffic between a character engine and a byte-wide register bus. It holds two independent byte queues. The receive queue is filled by the engine and drained when software reads the data register. The transmit queue is filled when software writes the data register and drained by the engine. Each queue holds up to 16 bytes when its queue mode is enabled. With its mode disabled, a queue holds a single byte.

The receive request is a sticky flag. It is raised once the receive fill level goes above a programmable mark. That mark can never be set lower than half the queue. Software acknowledges the flag through the status register. The transmit request follows the transmit fill level directly and is raised while that queue is running low. When a received byte cannot be stored, it is discarded and the overrun marker of the newest stored byte is set. When software writes a byte while the transmit queue has no room, the write is discarded.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both queues are empty and the configuration register reads 0x00. The status register reads 0x84, irq_tx is 1, irq_rx is 0 and tx_valid is 0.
- R2: The bus map is fixed. Offset 0x04 is the data register: a read pops a receive byte and a write pushes a transmit byte. Offset 0x0a is status and offset 0x0b is configuration. Configuration bits [2:0] set the threshold field, bit 3 enables receive queue mode and bit 7 enables transmit queue mode. The configuration register reads back what was written to those bits.
- R3: With a queue's mode bit set, the queue holds 16 bytes and returns them in arrival order.
- R4: With a queue's mode bit clear, the queue holds one byte. A second receive byte is dropped, and a second transmit write is ignored.
- R5: Status bit 3 and irq_rx become 1 one cycle after the receive count exceeds 8 plus the threshold field (receive mode on), or one cycle after the count becomes nonzero (receive mode off). They stay 1 while that condition holds.
- R6: Writing status with bit 3 set clears the receive flag only when the threshold condition no longer holds. Without that write, the flag stays 1 after the count falls.
- R7: Status bit 7 and irq_tx are 1 while the transmit count is below 8 (transmit mode on) or is zero (transmit mode off).
- R8: Status bit 4 is 1 when the transmit queue is full. A data write while full leaves the queue contents unchanged.
- R9: A receive byte that arrives while the receive queue is full is discarded. rx_head_ovr reads 1 when the last byte stored before the discard reaches the head, and 0 for every other byte.
- R10: Status bit 2 is 1 while the receive queue is empty. A data read while empty leaves the queue state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops on the data offset) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_head_ovr | output | 1 | Overrun marker of the byte at the receive head |
| tx_pop | input | 1 | Engine takes the transmit head byte |
| tx_byte | output | 8 | Transmit head byte |
| tx_valid | output | 1 | Transmit queue not empty |
| irq_rx | output | 1 | Receive threshold request (sticky) |
| irq_tx | output | 1 | Transmit low-level request |

## Verification
A push, pop or bus write changes the counts, the empty and full bits, irq_tx, tx_valid and the read data at the clock edge that accepts it. The receive flag and irq_rx need one more edge. The bench drives every strobe for exactly one edge, from one falling edge to the next. It samples combinational reads 1 ns after driving the address. Before it checks the receive flag, it always waits one further falling edge after the push that crosses the mark.

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int DEPTH     = 16,
  parameter int AW        = 5,
  parameter int DW        = 8,
  parameter logic [AW-1:0] ADDR_DATA = 5'h04,
  parameter logic [AW-1:0] ADDR_STAT = 5'h0a,
  parameter logic [AW-1:0] ADDR_CFG  = 5'h0b
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_head_ovr,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_byte,
  output logic          tx_valid,
  output logic          irq_rx,
  output logic          irq_tx
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int HALF = DEPTH / 2;

  logic [2:0]    cfg_thr;
  logic          cfg_rx_q, cfg_tx_q;
  logic [DW-1:0] rx_mem [DEPTH];
  logic          rx_ovr [DEPTH];
  logic [DW-1:0] tx_mem [DEPTH];
  logic [PW-1:0] rx_rd, rx_wr, tx_rd, tx_wr;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_flag;

  wire sel_data = (bus_addr == ADDR_DATA);
  wire sel_stat = (bus_addr == ADDR_STAT);
  wire sel_cfg  = (bus_addr == ADDR_CFG);

  wire [CW-1:0] rx_cap = cfg_rx_q ? CW'(DEPTH) : CW'(1);
  wire [CW-1:0] tx_cap = cfg_tx_q ? CW'(DEPTH) : CW'(1);
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt >= rx_cap);
  wire tx_full  = (tx_cnt >= tx_cap);

  wire rx_take = rx_push && !rx_full;
  wire rx_drop = rx_push && rx_full;
  wire rx_pop  = bus_re && sel_data && !rx_empty;
  wire tx_put  = bus_we && sel_data && !tx_full;
  wire tx_go   = tx_pop && (tx_cnt != '0);
  wire ack     = bus_we && sel_stat && bus_wdata[3];

  wire rx_cond = cfg_rx_q ? (rx_cnt > (CW'(HALF) + CW'(cfg_thr))) : !rx_empty;
  wire tx_low  = cfg_tx_q ? (tx_cnt < CW'(HALF)) : (tx_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_thr  <= '0;
      cfg_rx_q <= 1'b0;
      cfg_tx_q <= 1'b0;
    end else if (bus_we && sel_cfg) begin
      cfg_thr  <= bus_wdata[2:0];
      cfg_rx_q <= bus_wdata[3];
      cfg_tx_q <= bus_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rd <= '0; rx_wr <= '0; rx_cnt <= '0;
    end else begin
      if (rx_take) rx_wr <= rx_wr + 1'b1;
      if (rx_pop)  rx_rd <= rx_rd + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_take) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rx_take) begin
      rx_mem[rx_wr] <= rx_byte;
      rx_ovr[rx_wr] <= 1'b0;
    end
    if (rx_drop && !rx_empty) rx_ovr[PW'(rx_wr - 1'b1)] <= 1'b1;
    if (tx_put) tx_mem[tx_wr] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rd <= '0; tx_wr <= '0; tx_cnt <= '0;
    end else begin
      if (tx_put) tx_wr <= tx_wr + 1'b1;
      if (tx_go)  tx_rd <= tx_rd + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_put) - CW'(tx_go);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_flag <= 1'b0;
    else        rx_flag <= (rx_flag && !ack) || rx_cond;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data && !rx_empty) bus_rdata = rx_mem[rx_rd];
    else if (sel_stat) bus_rdata = {tx_low, 2'b00, tx_full, rx_flag, rx_empty, 2'b00};
    else if (sel_cfg)  bus_rdata = {cfg_tx_q, 3'b000, cfg_rx_q, cfg_thr};
  end

  assign rx_head_ovr = !rx_empty && rx_ovr[rx_rd];
  assign tx_byte     = tx_mem[tx_rd];
  assign tx_valid    = (tx_cnt != '0);
  assign irq_rx      = rx_flag;
  assign irq_tx      = tx_low;

  p_rx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));
  p_rx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !(bus_re && sel_data)) |=> $stable(rx_cnt));
  p_tx_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_data && tx_full && !tx_pop) |=> $stable(tx_cnt));
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cond |=> irq_rx);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rx_cond) |=> !irq_rx);
  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel_data && rx_empty && !rx_push) |=> (rx_cnt == '0));
endmodule

// File: tb/uart_fifo_pair_tb.sv
`timescale 1ns/1ps
module uart_fifo_pair_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic bus_we = 0, bus_re = 0, rx_push = 0, tx_pop = 0;
  logic [7:0] bus_wdata = '0, rx_byte = '0;
  logic [7:0] bus_rdata, tx_byte;
  logic rx_head_ovr, tx_valid, irq_rx, irq_tx;
  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [4:0] A_DATA = 5'h04, A_STAT = 5'h0a, A_CFG = 5'h0b;
  // {threshold field, bytes pushed, expected flag}
  localparam logic [8:0] THR_TAB [8] = '{
    {3'd0, 5'd8, 1'b0}, {3'd0, 5'd9, 1'b1}, {3'd3, 5'd11, 1'b0}, {3'd3, 5'd12, 1'b1},
    {3'd5, 5'd14, 1'b1}, {3'd7, 5'd15, 1'b0}, {3'd7, 5'd16, 1'b1}, {3'd2, 5'd13, 1'b1}};

  always #2.5 clk = ~clk;

  uart_fifo_pair u_dut (.clk, .rst_n, .bus_addr, .bus_we, .bus_re, .bus_wdata, .bus_rdata,
    .rx_push, .rx_byte, .rx_head_ovr, .tx_pop, .tx_byte, .tx_valid, .irq_rx, .irq_tx);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic take();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_STAT, d); chk("R1 status", d, 8'h84);
    rd(A_CFG, d);  chk("R1 config", d, 8'h00);
    chk("R1 irq_tx", irq_tx, 1); chk("R1 irq_rx", irq_rx, 0); chk("R1 tx_valid", tx_valid, 0);

    // R4 single-byte receive, R9 drop and overrun, R5 flag with mode off
    push(8'h11); push(8'h22);
    @(negedge clk);
    rd(A_STAT, d); chk("R5 flag mode off", d[3], 1); chk("R10 not empty", d[2], 0);
    chk("R5 irq_rx", irq_rx, 1);
    chk("R9 head overrun", rx_head_ovr, 1);
    rd(A_DATA, d); chk("R4 rx single byte", d, 8'h11);
    rd(A_STAT, d); chk("R10 empty", d[2], 1);
    wr(A_STAT, 8'h08); @(negedge clk);
    chk("R6 ack clears", irq_rx, 0);

    // R4 single-byte transmit, R7 and R8
    wr(A_DATA, 8'h33);
    rd(A_STAT, d); chk("R8 tx full mode off", d[4], 1); chk("R7 low off", d[7], 0);
    chk("R7 irq_tx", irq_tx, 0);
    wr(A_DATA, 8'h44);
    chk("R4 tx ignored", tx_byte, 8'h33);
    take();
    chk("R4 tx drained", tx_valid, 0); chk("R7 irq_tx back", irq_tx, 1);

    // R2 configuration readback
    wr(A_CFG, 8'h8D);
    rd(A_CFG, d); chk("R2 config readback", d, 8'h8D);
    wr(A_CFG, 8'h88);

    // R3 receive order and capacity, R9 overflow
    for (int i = 0; i < 17; i++) push(8'(i * 7 + 1));
    for (int i = 0; i < 16; i++) begin
      chk("R9 ovr marker", rx_head_ovr, (i == 15) ? 1 : 0);
      rd(A_DATA, d); chk("R3 rx order", d, 8'(i * 7 + 1));
    end
    rd(A_STAT, d); chk("R10 empty after drain", d[2], 1);
    wr(A_STAT, 8'h08);
    // R10 read while empty has no effect
    rd(A_DATA, d);
    push(8'h5A);
    rd(A_DATA, d); chk("R10 empty read harmless", d, 8'h5A);
    rd(A_STAT, d); chk("R10 empty again", d[2], 1);

    // R5 threshold table
    for (int t = 0; t < 8; t++) begin
      wr(A_CFG, {5'b10001, THR_TAB[t][8:6]});
      for (int k = 0; k < int'(THR_TAB[t][5:1]); k++) push(8'(k));
      @(negedge clk);
      rd(A_STAT, d);
      chk("R5 threshold flag", d[3], THR_TAB[t][0]);
      chk("R5 threshold irq", irq_rx, THR_TAB[t][0]);
      for (int k = 0; k < int'(THR_TAB[t][5:1]); k++) rd(A_DATA, d);
      wr(A_STAT, 8'h08);
    end

    // R6 ack while condition holds, then sticky after drop
    wr(A_CFG, 8'h88);
    for (int k = 0; k < 9; k++) push(8'(k));
    @(negedge clk);
    wr(A_STAT, 8'h08);
    rd(A_STAT, d); chk("R6 ack ignored while above", d[3], 1);
    rd(A_DATA, d); @(negedge clk);
    rd(A_STAT, d); chk("R6 sticky below mark", d[3], 1);
    wr(A_STAT, 8'h08);
    rd(A_STAT, d); chk("R6 ack after drop", d[3], 0);
    for (int k = 0; k < 8; k++) rd(A_DATA, d);

    // R3 transmit order, R7 low mark, R8 full and ignore
    for (int k = 0; k < 7; k++) wr(A_DATA, 8'(8'hA0 + k));
    rd(A_STAT, d); chk("R7 low at 7", d[7], 1);
    wr(A_DATA, 8'hA7);
    rd(A_STAT, d); chk("R7 not low at 8", d[7], 0); chk("R7 irq_tx at 8", irq_tx, 0);
    for (int k = 8; k < 16; k++) wr(A_DATA, 8'(8'hA0 + k));
    rd(A_STAT, d); chk("R8 tx full", d[4], 1);
    wr(A_DATA, 8'hEE);
    for (int k = 0; k < 16; k++) begin
      chk("R3 tx order", tx_byte, 8'(8'hA0 + k));
      take();
    end
    chk("R8 extra write absent", tx_valid, 0);

    finish_run();
  end
endmodule